// File: doc/BRIEF.md
# SPI Shift Engine (Master or Slave)

This block is the serial core of an SPI port. It holds one transmit character in a holding register, moves it into a shift register when the shifter is free, and then shifts that character out while it shifts a character in. A two-bit mode input selects the role. In master role the block generates SCK from the system clock and drives MOSI. In slave role it follows an external SCK and select and drives MISO through a tri-state enable. In master role the chip select is a general-purpose output under software control, so this block does not drive it.

On the bus-clock side the block has a one-cycle write strobe for the holding register, a receiver enable, and three flags. The data-empty flag tells software that another character can be written. The receive-done flag marks each completed character. The transmit-done flag marks the end of a transfer. Each completed character goes to an external receive buffer through a one-cycle push strobe. Frames are 8 bits, MSB first, in SPI mode 0: SCK idles low and data is sampled on the rising edge.

In slave role a newly written character is used only if it has settled for enough SCK rising edges before the next character boundary. If it has not, the shifter sends back the last character it received.

Top module: `spi_engine`

## Requirements
- R1: Mode value 2'b11 selects master and 2'b10 selects slave. Values 2'b00 and 2'b01 keep the block inactive: SCK stays low, `sdo_oe` stays low and a written character stays in the holding register.
- R2: In master role a character is 8 bits, MSB first on `sdo`. SCK idles low, is high for `clk_div+1` system cycles and low for `clk_div+1` system cycles, and toggles only while a character is in progress.
- R3: The holding register moves into the shifter only when the shifter is free. A character written during a transfer follows the current one with no idle SCK period between them.
- R4: `flag_dre` is 1 after reset. It goes to 0 on a write and rises exactly 3 system cycles after the holding register empties into the shifter, provided no new write has arrived.
- R5: With `rx_en` high, `rx_push` pulses for one cycle with `rx_char` holding the completed character, in the cycle in which the last bit is sampled, and `flag_rxc` sets in that cycle. With `rx_en` low there is no push, `flag_rxc` does not set and `rx_char` keeps its value.
- R6: In master role `flag_txc` sets when the last bit period of a character ends and the holding register is empty.
- R7: In slave role `sdo_oe` is low and the shifter is idle while `ss_n_i` is high. `sdo_oe` is high while `ss_n_i` is low.
- R8: In slave role, at the fall of select and at each character boundary, the shifter takes the written character only if at least 3 SCK rising edges have passed since the write. Otherwise it takes the character most recently received in slave role, which is 0 after reset.
- R9: In slave role `flag_txc` sets when `ss_n_i` returns high.
- R10: Writing 1 to `flag_clr[0]` clears `flag_rxc` and writing 1 to `flag_clr[1]` clears `flag_txc`. When a set and a clear fall in the same cycle, the set wins.
- R11: After reset `flag_rxc`, `flag_txc`, `rx_push` and `sck_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (bus) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Role select: 2'b11 master, 2'b10 slave, other values inactive |
| rx_en | input | 1 | Receiver enable |
| clk_div | input | DIVW | Master SCK half period minus one, in system cycles |
| wr_valid | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | W | Character to transmit |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 clears rxc, bit 1 clears txc |
| flag_dre | output | 1 | Holding register empty |
| flag_rxc | output | 1 | Receive complete |
| flag_txc | output | 1 | Transmit complete |
| rx_push | output | 1 | One-cycle strobe that hands `rx_char` to the receive buffer |
| rx_char | output | W | Last completed received character |
| sck_o | output | 1 | SCK driven in master role |
| sck_i | input | 1 | SCK from the pin in slave role |
| ss_n_i | input | 1 | Active-low select from the pin in slave role |
| sdi | input | 1 | Serial input (MISO in master role, MOSI in slave role) |
| sdo | output | 1 | Serial output (MOSI in master role, MISO in slave role) |
| sdo_oe | output | 1 | Output enable for `sdo` |

## Verification
The collision that matters is a software clear of the receive-done flag in the very cycle in which the last bit of a character is sampled. The behavioural model in the bench predicts that cycle from its own bit-period count. The bench raises `flag_clr[0]` for exactly that edge and then expects `flag_rxc` to read 1 next to the push strobe. A second race is a slave write that lands too close to a character boundary. The bench writes after the sixth SCK rise and expects the next character on `sdo` to be the echoed received byte. It expects the written byte only one character later.

// File: rtl/spi_eng_pkg.sv
// Package: shared role encoding for the SPI shift engine.
// Assumes the two-bit mode input is decoded only through this type.
package spi_eng_pkg;
    typedef enum logic [1:0] {
        ROLE_OFF_A  = 2'b00,
        ROLE_OFF_B  = 2'b01,
        ROLE_SLAVE  = 2'b10,
        ROLE_MASTER = 2'b11
    } spi_role_e;
endpackage

// File: rtl/spi_eng_sync.sv
// Module: multi-stage synchronizer for a group of pin inputs.
// Assumes each bit is independent; RST_VAL gives the idle level per bit.
module spi_eng_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage captures the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= din;
            end
        end else begin : g_next
            // Later stages settle metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/spi_eng_txreg.sv
// Module: transmit holding register with empty-flag latency and settle counter.
// Assumes load is asserted only while full is high; a write wins over a load.
module spi_eng_txreg #(
    parameter int W           = 8,
    parameter int DRE_LAT     = 3,
    parameter int READY_EDGES = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_valid,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    input  logic         edge_tick,
    output logic [W-1:0] tdr_q,
    output logic         full,
    output logic         ready,
    output logic         dre
);
    localparam int CW = $clog2(READY_EDGES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(READY_EDGES);

    logic [CW-1:0]      settle_cnt;
    logic [DRE_LAT-1:0] dre_pipe;

    // Holding register and its occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdr_q <= '0;
            full  <= 1'b0;
        end else if (wr_valid) begin
            tdr_q <= wr_data;
            full  <= 1'b1;
        end else if (load) begin
            full  <= 1'b0;
        end
    end

    // Counts SCK rising edges since the last write, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)                                     settle_cnt <= '0;
        else if (wr_valid)                              settle_cnt <= '0;
        else if (edge_tick && full && settle_cnt != CNT_MAX) settle_cnt <= settle_cnt + 1'b1;
    end

    if (DRE_LAT == 1) begin : g_lat1
        // Single-stage delay of the load event
        always_ff @(posedge clk) begin
            if (!rst_n) dre_pipe <= '0;
            else        dre_pipe <= load;
        end
    end else begin : g_latn
        // Multi-stage delay of the load event
        always_ff @(posedge clk) begin
            if (!rst_n) dre_pipe <= '0;
            else        dre_pipe <= {dre_pipe[DRE_LAT-2:0], load};
        end
    end

    // Empty flag: cleared by a write, set after the delayed load event
    always_ff @(posedge clk) begin
        if (!rst_n)                               dre <= 1'b1;
        else if (wr_valid)                        dre <= 1'b0;
        else if (dre_pipe[DRE_LAT-1] && !full)    dre <= 1'b1;
    end

    assign ready = full && (settle_cnt == CNT_MAX);
endmodule

// File: rtl/spi_eng_sckgen.sv
// Module: master SCK edge timer; emits one tick per SCK half period.
// Assumes div is held constant while run is high.
module spi_eng_sckgen #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    // Half-period counter, held at zero while idle
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run)         cnt <= '0;
        else if (cnt == div)   cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == div);
endmodule

// File: rtl/spi_engine.sv
// Module: full-duplex SPI shift engine, master or slave, SPI mode 0, MSB first.
// Assumes the select in master role is driven elsewhere, slave pins are
// asynchronous (synchronized here), and clk_div changes only while idle.
module spi_engine
    import spi_eng_pkg::*;
#(
    parameter int W           = 8,
    parameter int DIVW        = 8,
    parameter int DRE_LAT     = 3,
    parameter int READY_EDGES = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic            rx_en,
    input  logic [DIVW-1:0] clk_div,
    input  logic            wr_valid,
    input  logic [W-1:0]    wr_data,
    input  logic [1:0]      flag_clr,
    output logic            flag_dre,
    output logic            flag_rxc,
    output logic            flag_txc,
    output logic            rx_push,
    output logic [W-1:0]    rx_char,
    output logic            sck_o,
    input  logic            sck_i,
    input  logic            ss_n_i,
    input  logic            sdi,
    output logic            sdo,
    output logic            sdo_oe
);
    localparam int BW = $clog2(W);
    localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

    spi_role_e role;
    logic      is_mst, is_slv;
    logic      sck_s, ss_s, sdi_s, sck_p, ss_p;
    logic      busy, sck_q, skip;
    logic [BW-1:0] bit_idx;
    logic [W-1:0]  tx_sh, last_rx, tdr_q, rx_word;
    logic [W-2:0]  rx_sh;
    logic      tdr_full, tdr_ready, m_tick;
    logic      m_rise, m_fall, s_rise, s_fall, ss_fall, ss_rise;
    logic      any_rise, last_bit, bit_in, m_start, m_next, tdr_take;

    assign role   = spi_role_e'(mode);
    assign is_mst = (role == ROLE_MASTER);
    assign is_slv = (role == ROLE_SLAVE);

    spi_eng_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sck_i, ss_n_i, sdi}),
        .dout ({sck_s, ss_s, sdi_s})
    );

    spi_eng_sckgen #(.DIVW(DIVW)) u_sckgen (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (is_mst && busy),
        .div  (clk_div),
        .tick (m_tick)
    );

    spi_eng_txreg #(.W(W), .DRE_LAT(DRE_LAT), .READY_EDGES(READY_EDGES)) u_txreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .load     (tdr_take),
        .edge_tick(s_rise),
        .tdr_q    (tdr_q),
        .full     (tdr_full),
        .ready    (tdr_ready),
        .dre      (flag_dre)
    );

    // Edge decode for both roles
    always_comb begin
        m_rise   = m_tick && !sck_q;
        m_fall   = m_tick && sck_q;
        s_rise   = is_slv && !ss_s && sck_s && !sck_p;
        s_fall   = is_slv && !ss_s && !sck_s && sck_p;
        ss_fall  = is_slv && !ss_s && ss_p;
        ss_rise  = is_slv && ss_s && !ss_p;
        any_rise = m_rise || s_rise;
        last_bit = (bit_idx == LAST_BIT);
        bit_in   = is_mst ? sdi : sdi_s;
        rx_word  = {rx_sh, bit_in};
        m_start  = is_mst && !busy && tdr_full;
        m_next   = m_fall && last_bit;
        tdr_take = m_start || (m_next && tdr_full)
                 || ((ss_fall || (s_rise && last_bit)) && tdr_ready);
    end

    // Pin edge history for slave edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p <= 1'b0;
            ss_p  <= 1'b1;
        end else begin
            sck_p <= sck_s;
            ss_p  <= ss_s;
        end
    end

    // Transmit shifter, bit counter and master SCK level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sck_q   <= 1'b0;
            skip    <= 1'b0;
            bit_idx <= '0;
            tx_sh   <= '0;
        end else if (is_mst) begin
            if (m_start) begin
                busy    <= 1'b1;
                tx_sh   <= tdr_q;
                bit_idx <= '0;
            end else if (m_rise) begin
                sck_q <= 1'b1;
            end else if (m_fall) begin
                sck_q <= 1'b0;
                if (last_bit) begin
                    bit_idx <= '0;
                    if (tdr_full) tx_sh <= tdr_q;
                    else          busy  <= 1'b0;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                    tx_sh   <= {tx_sh[W-2:0], 1'b0};
                end
            end
        end else if (is_slv) begin
            if (ss_fall) begin
                tx_sh   <= tdr_ready ? tdr_q : last_rx;
                bit_idx <= '0;
                skip    <= 1'b0;
            end else if (s_rise) begin
                if (last_bit) begin
                    tx_sh   <= tdr_ready ? tdr_q : rx_word;
                    bit_idx <= '0;
                    skip    <= 1'b1;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end else if (s_fall) begin
                if (skip) skip  <= 1'b0;
                else      tx_sh <= {tx_sh[W-2:0], 1'b0};
            end
        end
    end

    // Receive shifter and hand-off to the receive buffer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            rx_char <= '0;
            rx_push <= 1'b0;
            last_rx <= '0;
        end else begin
            rx_push <= 1'b0;
            if (any_rise) begin
                rx_sh <= rx_word[W-2:0];
                if (last_bit) begin
                    if (rx_en) begin
                        rx_push <= 1'b1;
                        rx_char <= rx_word;
                    end
                    if (s_rise) last_rx <= rx_word;
                end
            end
        end
    end

    // Completion flags; a set in the same cycle wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_rxc <= 1'b0;
            flag_txc <= 1'b0;
        end else begin
            if (any_rise && last_bit && rx_en) flag_rxc <= 1'b1;
            else if (flag_clr[0])              flag_rxc <= 1'b0;
            if ((m_next && !tdr_full) || ss_rise) flag_txc <= 1'b1;
            else if (flag_clr[1])                 flag_txc <= 1'b0;
        end
    end

    assign sck_o  = is_mst && sck_q;
    assign sdo    = tx_sh[W-1];
    assign sdo_oe = is_mst || (is_slv && !ss_s);
endmodule

// File: rtl/spi_engine_chk.sv
// Module: property checker for spi_engine, attached by bind.
// Assumes it sees the top's ports plus its busy and holding-register state.
module spi_engine_chk #(
    parameter int DRE_LAT = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       ss_n_i,
    input logic       sdo_oe,
    input logic       sck_o,
    input logic       busy,
    input logic       tdr_full,
    input logic       flag_dre,
    input logic       flag_txc,
    input logic       flag_rxc,
    input logic       rx_push,
    input logic       rx_en
);
    int empty_cnt;

    // Counts consecutive cycles with an empty holding register
    always_ff @(posedge clk) begin
        if (!rst_n || tdr_full)     empty_cnt <= 0;
        else if (empty_cnt <= DRE_LAT) empty_cnt <= empty_cnt + 1;
    end

    p_inactive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] == 1'b0) |-> (!sck_o && !sdo_oe));

    p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && !busy) |-> !sck_o);

    p_dre_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_dre) |-> (empty_cnt >= DRE_LAT));

    p_dre_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_dre |-> !tdr_full);

    p_push_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> ($past(rx_en) && flag_rxc));

    p_txc_master_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_txc) && mode == 2'b11 && $past(mode) == 2'b11) |-> (!busy && !$past(tdr_full)));

    p_miso_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && ss_n_i && $past(ss_n_i) && $past(ss_n_i, 2) && $past(ss_n_i, 3)) |-> !sdo_oe);
endmodule

bind spi_engine spi_engine_chk #(.DRE_LAT(DRE_LAT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .ss_n_i  (ss_n_i),
    .sdo_oe  (sdo_oe),
    .sck_o   (sck_o),
    .busy    (busy),
    .tdr_full(tdr_full),
    .flag_dre(flag_dre),
    .flag_txc(flag_txc),
    .flag_rxc(flag_rxc),
    .rx_push (rx_push),
    .rx_en   (rx_en)
);

// File: tb/spi_engine_test.sv
// Bench: behavioural per-cycle model for master role, event checks for slave role.
module spi_engine_test;
    localparam int DRE_LAT = 3;
    localparam int HS      = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       rx_en = 1'b1;
    logic [7:0] clk_div = 8'd2;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] flag_clr = 2'b00;
    logic       sck_i = 1'b0;
    logic       ss_n_i = 1'b1;
    logic       sdi_slv = 1'b0;
    logic       sdi;
    logic       flag_dre, flag_rxc, flag_txc, rx_push, sck_o, sdo, sdo_oe;
    logic [7:0] rx_char;

    assign sdi = (mode == 2'b11) ? ~sdo : sdi_slv;

    spi_engine uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .rx_en(rx_en), .clk_div(clk_div),
        .wr_valid(wr_valid), .wr_data(wr_data), .flag_clr(flag_clr),
        .flag_dre(flag_dre), .flag_rxc(flag_rxc), .flag_txc(flag_txc),
        .rx_push(rx_push), .rx_char(rx_char), .sck_o(sck_o), .sck_i(sck_i),
        .ss_n_i(ss_n_i), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model state (master role and inactive modes)
    bit         mdl_on = 1'b1;
    bit         m_busy, m_full, m_dre, m_txc, m_rxc, m_push;
    int         m_t, m_half, m_dcnt;
    logic [7:0] m_cur, m_tdr, m_rxch;

    always @(posedge clk) begin
        bit set_rxc;
        bit set_txc;
        set_rxc = 1'b0;
        set_txc = 1'b0;
        if (!rst_n) begin
            m_busy = 0; m_full = 0; m_dre = 1; m_txc = 0; m_rxc = 0; m_push = 0;
            m_t = 0; m_half = 1; m_dcnt = -1; m_cur = 0; m_tdr = 0; m_rxch = 0;
        end else if (mdl_on) begin
            m_push = 0;
            if (m_dcnt == 0) begin
                if (!m_full && !wr_valid) m_dre = 1;
                m_dcnt = -1;
            end else if (m_dcnt > 0) m_dcnt--;
            if (m_busy) begin
                m_t++;
                if (m_t == 15 * m_half && rx_en) begin
                    m_push = 1; m_rxch = ~m_cur; set_rxc = 1;
                end
                if (m_t == 16 * m_half) begin
                    if (m_full) begin
                        m_cur = m_tdr; m_full = 0; m_t = 0;
                        m_half = int'(clk_div) + 1; m_dcnt = DRE_LAT - 1;
                    end else begin
                        m_busy = 0; set_txc = 1;
                    end
                end
            end else if (m_full && mode == 2'b11) begin
                m_busy = 1; m_cur = m_tdr; m_full = 0; m_t = 0;
                m_half = int'(clk_div) + 1; m_dcnt = DRE_LAT - 1;
            end
            if (wr_valid) begin m_tdr = wr_data; m_full = 1; m_dre = 0; end
            if (set_rxc) m_rxc = 1; else if (flag_clr[0]) m_rxc = 0;
            if (set_txc) m_txc = 1; else if (flag_clr[1]) m_txc = 0;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && mdl_on) begin
            chk("R2", "sck_o", int'(sck_o), m_busy ? ((m_t / m_half) % 2) : 0);
            if (m_busy) chk("R2", "sdo bit", int'(sdo), int'(m_cur[7 - m_t / (2 * m_half)]));
            chk("R4", "flag_dre", int'(flag_dre), int'(m_dre));
            chk("R5", "rx_push", int'(rx_push), int'(m_push));
            if (m_push) chk("R5", "rx_char", int'(rx_char), int'(m_rxch));
            chk("R10", "flag_rxc", int'(flag_rxc), int'(m_rxc));
            chk("R6", "flag_txc", int'(flag_txc), int'(m_txc));
        end
    end

    task automatic write_tdr(input logic [7:0] d);
        wr_valid = 1'b1; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic slv_char(input logic [7:0] mo, input logic [7:0] exp_mi,
                            input int late_i, input logic [7:0] late_d);
        logic [7:0] got;
        got = '0;
        for (int i = 0; i < 8; i++) begin
            sdi_slv = mo[7 - i];
            repeat (HS) @(negedge clk);
            got[7 - i] = sdo;
            sck_i = 1'b1;
            repeat (HS) @(negedge clk);
            if (i == late_i) begin
                write_tdr(late_d);
                chk("R4", "dre after slave write", int'(flag_dre), 0);
            end
            sck_i = 1'b0;
        end
        repeat (HS) @(negedge clk);
        chk("R8", "slave sdo character", int'(got), int'(exp_mi));
        chk("R5", "slave rx_char", int'(rx_char), int'(mo));
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "reset sck_o", int'(sck_o), 0);
        chk("R11", "reset rxc", int'(flag_rxc), 0);
        chk("R11", "reset txc", int'(flag_txc), 0);
        chk("R11", "reset rx_push", int'(rx_push), 0);
        chk("R4", "reset dre", int'(flag_dre), 1);

        // R1: inactive mode keeps the written character parked
        write_tdr(8'h5A);
        repeat (20) @(negedge clk);
        chk("R1", "inactive sdo_oe", int'(sdo_oe), 0);
        chk("R1", "inactive sck", int'(sck_o), 0);
        chk("R1", "inactive dre held low", int'(flag_dre), 0);

        // R3: master, second character chained during the first
        mode = 2'b11;
        repeat (4) @(negedge clk);
        chk("R1", "master sdo_oe", int'(sdo_oe), 1);
        write_tdr(8'hC3);
        while (!(m_busy && m_cur == 8'hC3 && m_t == 15 * m_half - 1)) @(negedge clk);
        flag_clr = 2'b01;
        @(negedge clk);
        flag_clr = 2'b00;
        chk("R10", "rxc set wins over clear", int'(flag_rxc), 1);
        chk("R5", "push on chained char", int'(rx_push), 1);
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R6", "txc after last char", int'(flag_txc), 1);
        chk("R3", "second char received", int'(rx_char), 8'h3C);
        flag_clr = 2'b11;
        @(negedge clk);
        flag_clr = 2'b00;
        chk("R10", "rxc cleared", int'(flag_rxc), 0);
        chk("R10", "txc cleared", int'(flag_txc), 0);

        // R5: fastest divider with receiver disabled
        clk_div = 8'd0;
        rx_en = 1'b0;
        write_tdr(8'h96);
        repeat (3) @(negedge clk);
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R5", "no rxc with rx off", int'(flag_rxc), 0);
        chk("R5", "rx_char kept with rx off", int'(rx_char), 8'h3C);
        chk("R6", "txc after single char", int'(flag_txc), 1);

        // Slave role
        mdl_on = 1'b0;
        @(negedge clk);
        mode = 2'b10;
        rx_en = 1'b1;
        flag_clr = 2'b11;
        @(negedge clk);
        flag_clr = 2'b00;
        repeat (4) @(negedge clk);
        chk("R7", "slave oe with select high", int'(sdo_oe), 0);
        write_tdr(8'hA5);
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        chk("R7", "slave oe with select low", int'(sdo_oe), 1);
        chk("R9", "txc low during select", int'(flag_txc), 0);
        slv_char(8'h3C, 8'h00, -1, 8'h00);
        slv_char(8'h81, 8'hA5, 5, 8'h77);
        slv_char(8'h42, 8'h81, -1, 8'h00);
        slv_char(8'hE7, 8'h77, -1, 8'h00);
        chk("R4", "dre after slave load", int'(flag_dre), 1);
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
        chk("R9", "txc on select rise", int'(flag_txc), 1);
        chk("R7", "oe off after select rise", int'(sdo_oe), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule